// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block collects nine UART event sources into one raw status vector, masks that vector with a software enable vector to give the pending status, and drives one registered interrupt line. Two sources are level conditions: the receive FIFO occupancy is compared against a programmable high-water mark, and the transmit FIFO occupancy is compared against a low-water mark. One source is a receive idle time-out, counted in character times by a small state machine. The remaining sources are edge events: single-cycle receive error strobes and any change on the synchronized CTS and DSR lines.

Software programs the block through a write port that selects one of four registers: the enable mask, a write-one-to-clear register, the two level thresholds, and the time-out setup. The raw and pending vectors are brought out as outputs for the read path. FIFO occupancy, the received-byte strobe, the character-time tick and the error strobes come from the neighbouring serial engine and FIFOs.

The time-out machine has three states. `TO_IDLE` (timer disabled or receive FIFO empty) moves to `TO_COUNT` once the timer is enabled and the FIFO holds data. `TO_COUNT` returns to `TO_IDLE` when either condition drops, restarts its count in place on a received byte, and moves to `TO_FIRED` on the tick that makes the count equal the threshold, raising the time-out event for that one cycle. `TO_FIRED` returns to `TO_COUNT` on a received byte or to `TO_IDLE` when the FIFO empties or the timer is disabled. Each line watcher has two states, `LINE_LOW` and `LINE_HIGH`, which follow the synchronized level; each transition between them is reported as a change.

Top module: `uart_irq_hub`

## Requirements
- R1: The raw vector holds, from bit 0 to bit 8: receive-full level, transmit-empty level, parity error, frame error, receive overflow, DSR change, CTS change, break detect, receive time-out.
- R2: `pend_status` equals `raw_status` ANDed with the enable mask, written at register address 0 (bits 8:0); the mask resets to 0. `irq` is the OR of `pend_status`, registered, so it follows one clock later.
- R3: A write to address 1 clears each raw bit whose data bit is 1; data bits that are 0 leave their raw bits unchanged.
- R4: When a source sets a raw bit in the same cycle as a clear of that bit, the bit stays set.
- R5: Raw bit 0 sets in every cycle in which `rx_count` is greater than the receive threshold (address 2, bits 6:0, reset value 0x60).
- R6: Raw bit 1 sets in every cycle in which `tx_count` is less than the transmit threshold (address 2, bits 14:8, reset value 0x60).
- R7: With the time-out enabled (address 3, bit 15) and a nonzero threshold (address 3, bits 6:0; both reset to 0), raw bit 8 sets on the character tick that brings the tick count since the last received byte to the threshold, counting only while `rx_count` is nonzero; a received byte restarts the count; a zero threshold, an empty FIFO or a cleared enable produces no time-out.
- R8: A one-cycle strobe on `parity_err_stb`, `frame_err_stb`, `rx_ovf_stb` or `break_stb` sets raw bit 2, 3, 4 or 7 respectively at the next clock edge.
- R9: Any rising or falling change of `cts_line` or `dsr_line` sets raw bit 6 or 5 on the third clock edge after the change, after two synchronizer flops.
- R10: After reset `raw_status`, `pend_status` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_byte_stb | input | 1 | One-cycle strobe per received byte |
| char_tick | input | 1 | One-cycle strobe per character time |
| parity_err_stb | input | 1 | Parity error strobe |
| frame_err_stb | input | 1 | Frame error strobe |
| rx_ovf_stb | input | 1 | Receive overflow strobe |
| break_stb | input | 1 | Break detect strobe |
| cts_line | input | 1 | Asynchronous CTS level |
| dsr_line | input | 1 | Asynchronous DSR level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 clear, 2 thresholds, 3 time-out |
| reg_wdata | input | WDATA_W | Register write data |
| raw_status | output | 9 | Raw event vector |
| pend_status | output | 9 | Raw vector masked by enables |
| irq | output | 1 | Registered interrupt line |

## Verification
The receive and transmit level comparisons are swept over every occupancy from 0 to 128 against thresholds 0, 1, 64, 96 and 127, each point followed by a clear, which separates a strict from a non-strict comparison and shows whether a clear loses to a condition still present. The enable mask is swept over all 512 values against a fixed raw pattern, so any crossed or missing mask bit and any wrong irq latency shows. Time-out runs cover thresholds 1 to 6 tick by tick, a restart by a received byte, an empty FIFO, a zero threshold and a disabled timer, which separates off-by-one counting from a missed restart. Each error strobe and each line edge is applied alone and the whole raw vector compared, which pins the bit order.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC     = 9;

    // Raw-vector bit positions (software decodes these)
    localparam int IDX_RXFULL  = 0;
    localparam int IDX_TXEMPTY = 1;
    localparam int IDX_PARITY  = 2;
    localparam int IDX_FRAME   = 3;
    localparam int IDX_OVF     = 4;
    localparam int IDX_DSR     = 5;
    localparam int IDX_CTS     = 6;
    localparam int IDX_BREAK   = 7;
    localparam int IDX_TOUT    = 8;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_LEVEL  = 2'd2,
        REG_TOUT   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } tout_state_e;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int CNT_W = 8,
    parameter int THR_W = 7
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    output logic             rx_full_set,
    output logic             tx_empty_set
);

    logic [CNT_W-1:0] rx_thr_ext;
    logic [CNT_W-1:0] tx_thr_ext;

    always_comb begin
        rx_thr_ext   = CNT_W'(rx_thr);
        tx_thr_ext   = CNT_W'(tx_thr);
        rx_full_set  = (rx_count > rx_thr_ext);
        tx_empty_set = (tx_count < tx_thr_ext);
    end

    // An empty receive FIFO can never exceed any threshold
    always_comb begin
        if (rx_count == '0)
            assert_empty_rx_quiet_R5: assert (!rx_full_set);
    end

    // A zero low-water mark can never be undercut
    always_comb begin
        if (tx_thr == '0)
            assert_zero_tx_thr_quiet_R6: assert (!tx_empty_set);
    end

endmodule

// File: rtl/irq_tout_fsm.sv
module irq_tout_fsm
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tout_en,
    input  logic [THR_W-1:0] tout_thr,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_byte,
    input  logic             char_tick,
    output logic             tout_fire
);

    tout_state_e      state_q;
    tout_state_e      state_nxt;
    logic [THR_W-1:0] tick_cnt_q;
    logic [THR_W-1:0] tick_cnt_inc;
    logic             leave;
    logic             hit;

    always_comb begin
        leave        = !tout_en || (rx_count == '0);
        tick_cnt_inc = tick_cnt_q + 1'b1;
        hit          = char_tick && (tout_thr != '0) && (tick_cnt_inc == tout_thr);
    end

    // Next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            TO_IDLE: begin
                if (!leave)
                    state_nxt = TO_COUNT;
            end
            TO_COUNT: begin
                if (leave)
                    state_nxt = TO_IDLE;
                else if (rx_byte)
                    state_nxt = TO_COUNT;
                else if (hit)
                    state_nxt = TO_FIRED;
            end
            TO_FIRED: begin
                if (leave)
                    state_nxt = TO_IDLE;
                else if (rx_byte)
                    state_nxt = TO_COUNT;
            end
            default: state_nxt = TO_IDLE;
        endcase
    end

    // State and tick counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TO_IDLE;
            tick_cnt_q <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == TO_COUNT && state_nxt == TO_COUNT && !rx_byte) begin
                if (char_tick)
                    tick_cnt_q <= tick_cnt_inc;
            end else begin
                tick_cnt_q <= '0;
            end
        end
    end

    // Output: the event is the COUNT -> FIRED transition
    always_comb begin
        tout_fire = (state_q == TO_COUNT) && (state_nxt == TO_FIRED);
    end

    assert_no_fire_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !tout_fire);

    assert_no_fire_zero_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_thr == '0) |-> !tout_fire);

    assert_single_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tout_fire |=> !tout_fire);

endmodule

// File: rtl/irq_line_watch.sv
module irq_line_watch
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_changed
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_sync;
    line_state_e            state_q;
    line_state_e            state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_async};
    end

    always_comb begin
        line_sync = sync_q[SYNC_STAGES-1];
        state_nxt = state_q;
        unique case (state_q)
            LINE_LOW:  if (line_sync)  state_nxt = LINE_HIGH;
            LINE_HIGH: if (!line_sync) state_nxt = LINE_LOW;
            default:   state_nxt = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LINE_LOW;
        else
            state_q <= state_nxt;
    end

    always_comb begin
        line_changed = (state_q == LINE_LOW  &&  line_sync) ||
                       (state_q == LINE_HIGH && !line_sync);
    end

    assert_change_moves_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_changed |=> (state_q != $past(state_q)));

    assert_quiet_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_changed |=> $stable(state_q));

endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
    import uart_irq_pkg::*;
#(
    parameter int CNT_W           = 8,
    parameter int THR_W           = 7,
    parameter int WDATA_W         = 16,
    parameter int SYNC_STAGES     = 2,
    parameter int LEVEL_THR_RESET = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               rx_byte_stb,
    input  logic               char_tick,
    input  logic               parity_err_stb,
    input  logic               frame_err_stb,
    input  logic               rx_ovf_stb,
    input  logic               break_stb,
    input  logic               cts_line,
    input  logic               dsr_line,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [8:0]         raw_status,
    output logic [8:0]         pend_status,
    output logic               irq
);

    localparam int TX_LSB      = 8;
    localparam int TOUT_EN_BIT = WDATA_W - 1;
    localparam int NUM_LINES   = 2;
    localparam logic [THR_W-1:0] THR_RST = THR_W'(LEVEL_THR_RESET);

    reg_addr_e          addr_sel;
    logic [NUM_SRC-1:0] en_q;
    logic [THR_W-1:0]   rx_thr_q;
    logic [THR_W-1:0]   tx_thr_q;
    logic [THR_W-1:0]   tout_thr_q;
    logic               tout_en_q;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               irq_q;
    logic               rx_full_set;
    logic               tx_empty_set;
    logic               tout_fire;
    logic [NUM_LINES-1:0] line_in;
    logic [NUM_LINES-1:0] line_chg;

    assign addr_sel = reg_addr_e'(reg_addr);

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            rx_thr_q   <= THR_RST;
            tx_thr_q   <= THR_RST;
            tout_thr_q <= '0;
            tout_en_q  <= 1'b0;
        end else if (reg_wr) begin
            unique case (addr_sel)
                REG_ENABLE: en_q <= reg_wdata[NUM_SRC-1:0];
                REG_LEVEL: begin
                    rx_thr_q <= reg_wdata[THR_W-1:0];
                    tx_thr_q <= reg_wdata[TX_LSB +: THR_W];
                end
                REG_TOUT: begin
                    tout_thr_q <= reg_wdata[THR_W-1:0];
                    tout_en_q  <= reg_wdata[TOUT_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_vec = (reg_wr && addr_sel == REG_CLEAR) ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    // Source generators
    irq_level_cmp #(
        .CNT_W(CNT_W),
        .THR_W(THR_W)
    ) u_level (
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .rx_thr      (rx_thr_q),
        .tx_thr      (tx_thr_q),
        .rx_full_set (rx_full_set),
        .tx_empty_set(tx_empty_set)
    );

    irq_tout_fsm #(
        .CNT_W(CNT_W),
        .THR_W(THR_W)
    ) u_tout (
        .clk      (clk),
        .rst_n    (rst_n),
        .tout_en  (tout_en_q),
        .tout_thr (tout_thr_q),
        .rx_count (rx_count),
        .rx_byte  (rx_byte_stb),
        .char_tick(char_tick),
        .tout_fire(tout_fire)
    );

    // Line 0 watches DSR, line 1 watches CTS
    assign line_in = {cts_line, dsr_line};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irq_line_watch #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_watch (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_async  (line_in[l]),
            .line_changed(line_chg[l])
        );
    end

    always_comb begin
        set_vec              = '0;
        set_vec[IDX_RXFULL]  = rx_full_set;
        set_vec[IDX_TXEMPTY] = tx_empty_set;
        set_vec[IDX_PARITY]  = parity_err_stb;
        set_vec[IDX_FRAME]   = frame_err_stb;
        set_vec[IDX_OVF]     = rx_ovf_stb;
        set_vec[IDX_DSR]     = line_chg[0];
        set_vec[IDX_CTS]     = line_chg[1];
        set_vec[IDX_BREAK]   = break_stb;
        set_vec[IDX_TOUT]    = tout_fire;
    end

    // Raw latches: set has priority over clear
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_raw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                raw_q[i] <= 1'b0;
            else
                raw_q[i] <= (raw_q[i] & ~clr_vec[i]) | set_vec[i];
        end

        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> raw_q[i]);

        assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !raw_q[i]);

        assert_zero_write_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[i] && !clr_vec[i]) |=> raw_q[i]);
    end

    always_comb begin
        pend = raw_q & en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pend;
    end

    assert_irq_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_q);

    assert_irq_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !irq_q);

    assign raw_status  = raw_q;
    assign pend_status = pend;
    assign irq         = irq_q;

endmodule

// File: tb/test_uart_irq_hub.sv
module test_uart_irq_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_count = '0;
    logic [7:0]  tx_count = 8'd100;
    logic        rx_byte_stb = 1'b0;
    logic        char_tick = 1'b0;
    logic        parity_err_stb = 1'b0;
    logic        frame_err_stb = 1'b0;
    logic        rx_ovf_stb = 1'b0;
    logic        break_stb = 1'b0;
    logic        cts_line = 1'b0;
    logic        dsr_line = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [8:0]  raw_status;
    logic [8:0]  pend_status;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    uart_irq_hub i_uart_irq_hub (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .rx_byte_stb(rx_byte_stb), .char_tick(char_tick),
        .parity_err_stb(parity_err_stb), .frame_err_stb(frame_err_stb),
        .rx_ovf_stb(rx_ovf_stb), .break_stb(break_stb),
        .cts_line(cts_line), .dsr_line(dsr_line),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .raw_status(raw_status), .pend_status(pend_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1; @(negedge clk);
        char_tick = 1'b0; @(negedge clk);
    endtask

    task automatic rx_byte();
        rx_byte_stb = 1'b1; @(negedge clk);
        rx_byte_stb = 1'b0; @(negedge clk);
    endtask

    task automatic tout_setup(input int thr, input logic en, input logic [7:0] cnt);
        wr(2'd3, 16'h0000);
        rx_count = cnt;
        wr(2'd1, 16'h01FF);
        wr(2'd3, {en, 8'h00, 7'(thr)});
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int thr_list[5] = '{0, 1, 64, 96, 127};
        logic [8:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 raw", 32'(raw_status), 0);
        chk("R10 pend", 32'(pend_status), 0);
        chk("R10 irq", 32'(irq), 0);

        // R5 reset threshold 0x60: 96 not above, 97 above
        rx_count = 8'd96; @(negedge clk);
        chk("R5 reset thr 96", 32'(raw_status[0]), 0);
        rx_count = 8'd97; @(negedge clk);
        chk("R5 reset thr 97", 32'(raw_status[0]), 1);
        rx_count = 8'd0; wr(2'd1, 16'h01FF);
        // R6 reset threshold 0x60
        tx_count = 8'd96; @(negedge clk);
        chk("R6 reset thr 96", 32'(raw_status[1]), 0);
        tx_count = 8'd95; @(negedge clk);
        chk("R6 reset thr 95", 32'(raw_status[1]), 1);
        tx_count = 8'd100; wr(2'd1, 16'h01FF);

        // R5 sweep: raw0 after a clear equals (count > thr); R4 when it holds
        foreach (thr_list[t]) begin
            wr(2'd2, {1'b0, 7'd0, 1'b0, 7'(thr_list[t])});
            for (int c = 0; c <= 128; c++) begin
                rx_count = 8'(c);
                @(negedge clk);
                wr(2'd1, 16'h0001);
                chk("R5 R4 rx level", 32'(raw_status[0]), 32'(c > thr_list[t]));
            end
            rx_count = 8'd0;
            @(negedge clk);
            wr(2'd1, 16'h0001);
        end

        // R6 sweep: raw1 after a clear equals (count < thr)
        foreach (thr_list[t]) begin
            wr(2'd2, {1'b0, 7'(thr_list[t]), 1'b0, 7'd127});
            for (int c = 0; c <= 128; c++) begin
                tx_count = 8'(c);
                @(negedge clk);
                wr(2'd1, 16'h0002);
                chk("R6 R4 tx level", 32'(raw_status[1]), 32'(c < thr_list[t]));
            end
        end
        tx_count = 8'd100;
        wr(2'd2, {1'b0, 7'h60, 1'b0, 7'd127});
        wr(2'd1, 16'h01FF);
        chk("R3 all cleared", 32'(raw_status), 0);

        // R8 and R1: each strobe sets exactly its bit
        parity_err_stb = 1'b1; @(negedge clk); parity_err_stb = 1'b0;
        chk("R8 R1 parity bit2", 32'(raw_status), 32'h004);
        wr(2'd1, 16'h01FF);
        frame_err_stb = 1'b1; @(negedge clk); frame_err_stb = 1'b0;
        chk("R8 R1 frame bit3", 32'(raw_status), 32'h008);
        wr(2'd1, 16'h01FF);
        rx_ovf_stb = 1'b1; @(negedge clk); rx_ovf_stb = 1'b0;
        chk("R8 R1 overflow bit4", 32'(raw_status), 32'h010);
        wr(2'd1, 16'h01FF);
        break_stb = 1'b1; @(negedge clk); break_stb = 1'b0;
        chk("R8 R1 break bit7", 32'(raw_status), 32'h080);

        // R3: zero bits do not clear, other bits leave it alone
        wr(2'd1, 16'h0000);
        chk("R3 zero write", 32'(raw_status), 32'h080);
        wr(2'd1, 16'h017F);
        chk("R3 other bits", 32'(raw_status), 32'h080);
        wr(2'd1, 16'h0080);
        chk("R3 clear bit7", 32'(raw_status), 0);

        // R4: strobe and clear in the same cycle
        parity_err_stb = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004;
        @(negedge clk);
        parity_err_stb = 1'b0; reg_wr = 1'b0;
        chk("R4 set beats clear", 32'(raw_status), 32'h004);
        wr(2'd1, 16'h0004);

        // R9: CTS and DSR, both edges, three-edge latency
        cts_line = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 cts rise not yet", 32'(raw_status), 0);
        @(negedge clk);
        chk("R9 R1 cts rise bit6", 32'(raw_status), 32'h040);
        wr(2'd1, 16'h0040);
        cts_line = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 cts fall bit6", 32'(raw_status), 32'h040);
        wr(2'd1, 16'h0040);
        dsr_line = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 dsr rise not yet", 32'(raw_status), 0);
        @(negedge clk);
        chk("R9 R1 dsr rise bit5", 32'(raw_status), 32'h020);
        wr(2'd1, 16'h0020);
        dsr_line = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 dsr fall bit5", 32'(raw_status), 32'h020);
        wr(2'd1, 16'h01FF);

        // R7: thresholds 1..6, checked tick by tick
        for (int t = 1; t <= 6; t++) begin
            tout_setup(t, 1'b1, 8'd5);
            rx_byte();
            for (int k = 1; k <= t; k++) begin
                tick();
                chk("R7 R1 timeout bit8", 32'(raw_status), (k >= t) ? 32'h100 : 0);
            end
        end
        // R7 restart by a received byte
        tout_setup(4, 1'b1, 8'd5);
        rx_byte();
        repeat (3) tick();
        rx_byte();
        repeat (3) tick();
        chk("R7 restart", 32'(raw_status[8]), 0);
        tick();
        chk("R7 after restart", 32'(raw_status[8]), 1);
        // R7 empty FIFO, zero threshold, disabled
        tout_setup(2, 1'b1, 8'd0);
        rx_byte();
        repeat (5) tick();
        chk("R7 empty fifo", 32'(raw_status[8]), 0);
        tout_setup(0, 1'b1, 8'd5);
        rx_byte();
        repeat (5) tick();
        chk("R7 zero thr", 32'(raw_status[8]), 0);
        tout_setup(2, 1'b0, 8'd5);
        rx_byte();
        repeat (5) tick();
        chk("R7 disabled", 32'(raw_status[8]), 0);
        wr(2'd3, 16'h0000);
        rx_count = 8'd0;
        wr(2'd1, 16'h01FF);

        // R2: full enable-mask sweep over a fixed raw pattern
        parity_err_stb = 1'b1; frame_err_stb = 1'b1;
        rx_ovf_stb = 1'b1; break_stb = 1'b1;
        @(negedge clk);
        parity_err_stb = 1'b0; frame_err_stb = 1'b0;
        rx_ovf_stb = 1'b0; break_stb = 1'b0;
        pat = 9'h09C;
        chk("R8 pattern", 32'(raw_status), 32'(pat));
        for (int e = 0; e < 512; e++) begin
            wr(2'd0, 16'(e));
            chk("R2 pend mask", 32'(pend_status), 32'(pat & 9'(e)));
            @(negedge clk);
            chk("R2 irq", 32'(irq), 32'(|(pat & 9'(e))));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule